// File: doc/BRIEF.md
# Hardware Return Stack Unit

This unit keeps a small last-in-first-out store of 16-bit words, such as return addresses, for a processor core. The core signals a store with a push strobe and a retrieve with a pop strobe. It also reaches the stack pointer through a 16-bit register port. Through that port software can read the pointer or move it to any slot. Call and return sequencing stays in the core.

The pointer is 4 bits wide and walks a ring of 16 slots. A push writes the word into the slot the pointer names, then advances the pointer by one. A pop steps the pointer back by one and returns the word in the slot it then names. The word a pop would return is shown on the output at all times, so it is valid in the same cycle as the pop strobe. The unit has no overflow or underflow flag. It does not spill to memory.

Top module: `hw_return_stack`

## Requirements
- R1: A synchronous reset sets the pointer register to read 16'h000F.
- R2: A push without pop or pointer write stores push data into the slot at the current pointer. The pointer then reads one higher, and the top-of-stack output shows the pushed word in the next cycle.
- R3: The top-of-stack output always shows the slot at pointer minus one. A pop without push or pointer write returns that word in its own cycle and lowers the pointer by one at the clock edge.
- R4: Bits 15 to 4 of the pointer register always read as zero, and the values written to those bits have no effect.
- R5: A pointer write loads bits 3 to 0 of the write data into the pointer, and the new value reads back from the next cycle.
- R6: The pointer wraps modulo 16: a push at index 15 leaves it at 0, and a pop at index 0 leaves it at 15.
- R7: A push and a pop in the same cycle change neither the pointer nor any stored slot.
- R8: A pointer write in the same cycle as a push or pop wins: the pointer takes the written value and no slot is written.
- R9: Reset leaves the slot contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Store push_data_i and advance pointer |
| pop_i | input | 1 | Retreat pointer, returning the top word |
| push_data_i | input | 16 | Word to store on push |
| sp_wr_i | input | 1 | Write strobe for the pointer register |
| sp_wdata_i | input | 16 | Pointer register write data (bits 3:0 used) |
| pop_data_o | output | 16 | Word in slot pointer-minus-one |
| sp_rdata_o | output | 16 | Pointer register, zero-extended |

## Verification
Three kinds of event can land in one cycle: a push, a pop, and a software write to the pointer. The bench drives push and pop together and checks that the pointer and the top word are unchanged. It then drives a pointer write together with a push, and another together with a pop. After each, it checks that the pointer holds the written value and that the slot the push would have written still has its old contents. A scoreboard predicts each popped word from a model built from the requirements. The pushes used to fill the model also wrap the full ring of 16 slots.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_LOAD = 2'd3
    } rstk_op_e;

    typedef struct packed {
        logic slot_we;
        logic step_up;
        logic step_dn;
        logic load;
    } rstk_ctl_t;

    // Pointer write outranks the strobes; push with pop cancels out.
    function automatic rstk_op_e rstk_decode(logic push, logic pop, logic wr);
        if (wr)
            return OP_LOAD;
        else if (push && !pop)
            return OP_PUSH;
        else if (pop && !push)
            return OP_POP;
        else
            return OP_HOLD;
    endfunction

    function automatic rstk_ctl_t rstk_controls(rstk_op_e op);
        rstk_ctl_t c;
        c = '0;
        case (op)
            OP_PUSH: begin c.slot_we = 1'b1; c.step_up = 1'b1; end
            OP_POP:  c.step_dn = 1'b1;
            OP_LOAD: c.load    = 1'b1;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rstk_ptr.sv
module rstk_ptr
    import rstk_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  rstk_ctl_t        ctl,
    input  logic [PTR_W-1:0] load_val,
    output logic [PTR_W-1:0] ptr,
    output logic [PTR_W-1:0] ptr_below
);
    localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);
    localparam logic [PTR_W-1:0] PTR_LAST = '1;

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= PTR_LAST;
        else if (ctl.load)
            ptr <= load_val;
        else if (ctl.step_up)
            ptr <= ptr + PTR_ONE;
        else if (ctl.step_dn)
            ptr <= ptr - PTR_ONE;
    end

    assign ptr_below = ptr - PTR_ONE;
endmodule

// File: rtl/rstk_mem.sv
module rstk_mem #(
    parameter int WORD_W = 16,
    parameter int PTR_W  = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << PTR_W;

    logic [WORD_W-1:0] slot [DEPTH];

    // Slots carry no reset: contents survive a reset.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (waddr == PTR_W'(g)))
                slot[g] <= wdata;
        end
    end

    assign rdata = slot[raddr];
endmodule

// File: rtl/hw_return_stack.sv
module hw_return_stack
    import rstk_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int PTR_W  = 4,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [WORD_W-1:0] push_data_i,
    input  logic              sp_wr_i,
    input  logic [REG_W-1:0]  sp_wdata_i,
    output logic [WORD_W-1:0] pop_data_o,
    output logic [REG_W-1:0]  sp_rdata_o
);
    localparam int PAD_W = REG_W - PTR_W;

    rstk_op_e         op;
    rstk_ctl_t        ctl;
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] ptr_below;
    logic             unused_hi;

    assign op  = rstk_decode(push_i, pop_i, sp_wr_i);
    assign ctl = rstk_controls(op);

    // Upper register bits are dropped on write.
    assign unused_hi = ^sp_wdata_i[REG_W-1:PTR_W];

    rstk_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .load_val (sp_wdata_i[PTR_W-1:0]),
        .ptr      (ptr),
        .ptr_below(ptr_below)
    );

    rstk_mem #(.WORD_W(WORD_W), .PTR_W(PTR_W)) u_mem (
        .clk  (clk),
        .we   (ctl.slot_we),
        .waddr(ptr),
        .wdata(push_data_i),
        .raddr(ptr_below),
        .rdata(pop_data_o)
    );

    assign sp_rdata_o = {{PAD_W{1'b0}}, ptr};
endmodule

// File: rtl/rstk_chk.sv
module rstk_chk #(
    parameter int WORD_W = 16,
    parameter int PTR_W  = 4,
    parameter int REG_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              push_i,
    input logic              pop_i,
    input logic              sp_wr_i,
    input logic [REG_W-1:0]  sp_wdata_i,
    input logic [WORD_W-1:0] push_data_i,
    input logic [WORD_W-1:0] pop_data_o,
    input logic [REG_W-1:0]  sp_rdata_o
);
    localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);
    localparam logic [REG_W-1:0] RVAL = REG_W'((1 << PTR_W) - 1);

    p_reset_value_r1: assert property (@(posedge clk)
        rst |=> (sp_rdata_o == RVAL));

    p_push_step_r2: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && !sp_wr_i) |=>
        (sp_rdata_o[PTR_W-1:0] == $past(sp_rdata_o[PTR_W-1:0]) + ONE));

    p_push_top_r2: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && !sp_wr_i) |=> (pop_data_o == $past(push_data_i)));

    p_pop_step_r3: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && !sp_wr_i) |=>
        (sp_rdata_o[PTR_W-1:0] == $past(sp_rdata_o[PTR_W-1:0]) - ONE));

    p_both_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i && !sp_wr_i) |=>
        ($stable(sp_rdata_o) && $stable(pop_data_o)));

    p_write_wins_r8: assert property (@(posedge clk) disable iff (rst)
        sp_wr_i |=> (sp_rdata_o[PTR_W-1:0] == $past(sp_wdata_i[PTR_W-1:0])));
endmodule

bind hw_return_stack rstk_chk #(
    .WORD_W(WORD_W), .PTR_W(PTR_W), .REG_W(REG_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .sp_wr_i    (sp_wr_i),
    .sp_wdata_i (sp_wdata_i),
    .push_data_i(push_data_i),
    .pop_data_o (pop_data_o),
    .sp_rdata_o (sp_rdata_o)
);

// File: tb/sim_hw_return_stack.sv
module sim_hw_return_stack;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_i = 1'b0;
    logic        pop_i = 1'b0;
    logic [15:0] push_data_i = '0;
    logic        sp_wr_i = 1'b0;
    logic [15:0] sp_wdata_i = '0;
    logic [15:0] pop_data_o;
    logic [15:0] sp_rdata_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    logic [15:0] m_mem [16];
    logic [3:0]  m_sp = 4'hF;

    hw_return_stack u0 (
        .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i),
        .push_data_i(push_data_i), .sp_wr_i(sp_wr_i), .sp_wdata_i(sp_wdata_i),
        .pop_data_o(pop_data_o), .sp_rdata_o(sp_rdata_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and updates the model.
    task automatic drive(logic pu, logic po, logic wr, logic [15:0] pd, logic [15:0] wd);
        @(negedge clk);
        push_i = pu; pop_i = po; sp_wr_i = wr; push_data_i = pd; sp_wdata_i = wd;
        if (wr)
            m_sp = wd[3:0];
        else if (pu && !po) begin
            m_mem[m_sp] = pd;
            m_sp = m_sp + 4'd1;
        end else if (po && !pu) begin
            m_sp = m_sp - 4'd1;
            exp_q.push_back(m_mem[m_sp]);
        end
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, 16'h0, 16'h0);
    endtask

    task automatic check_sp(string tag);
        idle();
        #(CLK_P/4);
        check16(tag, sp_rdata_o, {12'h000, m_sp});
    endtask

    task automatic check_top(string tag);
        idle();
        #(CLK_P/4);
        check16(tag, pop_data_o, m_mem[m_sp - 4'd1]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; push_i = 0; pop_i = 0; sp_wr_i = 0;
        @(negedge clk);
        rst = 1'b0;
        m_sp = 4'hF;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Monitor: compares each pop's returned word with the scoreboard (R3).
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (!rst && pop_i && !push_i && !sp_wr_i) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R3 actual %h expected <none queued>", pop_data_o);
            end else begin
                check16("R3 pop word", pop_data_o, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_sp = 4'hF;
        check_sp("R1 reset pointer");

        // R4/R5: upper bits dropped, lower bits loaded
        drive(1'b0, 1'b0, 1'b1, 16'h0, 16'hFFF5);
        check_sp("R4 R5 pointer write");

        // R6: push at index 15 wraps to 0
        drive(1'b0, 1'b0, 1'b1, 16'h0, 16'h000F);
        drive(1'b1, 1'b0, 1'b0, 16'hA001, 16'h0);
        check_sp("R6 push wrap");
        check_top("R2 pushed word on top");
        drive(1'b1, 1'b0, 1'b0, 16'hB002, 16'h0);
        drive(1'b1, 1'b0, 1'b0, 16'hC003, 16'h0);
        drive(1'b1, 1'b0, 1'b0, 16'hD004, 16'h0);
        check_sp("R2 pointer after pushes");
        repeat (3) drive(1'b0, 1'b1, 1'b0, 16'h0, 16'h0);
        check_sp("R3 pointer after pops");
        drive(1'b0, 1'b1, 1'b0, 16'h0, 16'h0);
        check_sp("R6 pointer back to 15");

        // R6: pop at index 0 wraps to 15
        drive(1'b0, 1'b0, 1'b1, 16'h0, 16'h0000);
        drive(1'b0, 1'b1, 1'b0, 16'h0, 16'h0);
        check_sp("R6 pop wrap");

        // R7: push with pop is a no-op
        drive(1'b1, 1'b0, 1'b0, 16'h1234, 16'h0);
        drive(1'b1, 1'b1, 1'b0, 16'h5555, 16'h0);
        check_sp("R7 pointer held");
        check_top("R7 top word held");

        // R8: pointer write beats push and pop
        drive(1'b1, 1'b0, 1'b1, 16'h9999, 16'h0003);
        check_sp("R8 write beats push");
        drive(1'b0, 1'b0, 1'b1, 16'h0, 16'h0001);
        check_top("R8 slot 0 not written");
        drive(1'b0, 1'b1, 1'b1, 16'h0, 16'h0007);
        check_sp("R8 write beats pop");

        // R9: slot contents survive reset
        drive(1'b0, 1'b0, 1'b1, 16'h0, 16'h000E);
        drive(1'b1, 1'b0, 1'b0, 16'h5A5A, 16'h0);
        do_reset();
        check_sp("R1 pointer after second reset");
        check_top("R9 slot kept through reset");

        // Fill all 16 slots around the ring, then drain in reverse (R2 R3 R6)
        for (int i = 0; i < 16; i++)
            drive(1'b1, 1'b0, 1'b0, 16'h4000 + 16'(i * 17), 16'h0);
        check_sp("R6 full ring pointer");
        for (int i = 0; i < 16; i++)
            drive(1'b0, 1'b1, 1'b0, 16'h0, 16'h0);
        idle();
        idle();
        check16("R3 scoreboard drained", 16'(exp_q.size()), 16'h0);

        done = 1'b1;
        finish_run();
    end
endmodule